// File: doc/BRIEF.md
# Macroblock Neighbor Motion-Vector Buffer

This block holds the motion vectors that a macroblock decoder needs from neighboring 8x8 blocks. It does not keep a vector field for the whole frame. It has two stores. The first is a line store with one vector for each 8x8 block of the block row above the current macroblock. The second is a working array of ten slots: the four 8x8 blocks of the current macroblock, the two blocks above it, the block above and to the right, and three slots on the left (above-left, left of the top row, left of the bottom row). Every slot carries an availability flag. A cleared flag marks a slot that lies outside the picture, has not been decoded yet, or belongs to an intra macroblock.

The decoder hands over the vectors of a finished macroblock together with its partition type, its index within the row and an intra flag. It then pulses `mb_done`. The block writes the current slots, duplicating the vector of a large partition into each 8x8 slot it covers. It then runs three copy steps, one per cycle, in a fixed order:

1. The right-column vectors move to the left slots.
2. The bottom pair of vectors goes into the line store.
3. The next macroblock's above vectors are fetched from the line store.

`ready` stays low while these steps run. A frame-start strobe marks every slot and every line-store entry unavailable. A row-start strobe clears the left slots and loads the above slots for macroblock 0. Any slot can be read combinationally through a slot selector.

Top module: `mv_nbr_buf`

## Requirements
- R1: After reset and one cycle after `frame_start`, all ten slots and every line-store entry read unavailable, and `ready` is 1 while idle.
- R2: On `mb_done`, the current slots take the supplied vectors according to `mb_part`:
  - 0 = 16x16: source 0 goes to all four slots.
  - 1 = 16x8: source 0 goes to the top pair, source 1 to the bottom pair.
  - 2 = 8x16: source 0 goes to the left column, source 1 to the right column.
  - 3 = 8x8: source k goes to slot k.
  - Slot select codes: 0..3 = current blocks in raster order, 4 = above of block 0, 5 = above of block 1, 6 = above-right, 7 = above-left, 8 = left of top row, 9 = left of bottom row. Codes 10..15 read unavailable.
- R3: When `mb_intra` is 1 at `mb_done`, the four current slots become unavailable whatever the partition.
- R4: Copy step one sets the above-left slot to the old slot 5, the top-left slot to slot 1, and the bottom-left slot to slot 3.
- R5: Copy step two writes slots 2 and 3 into line-store entries 2n and 2n+1 for macroblock index n.
- R6: Copy step three loads slots 4, 5 and 6 from line-store entries 2n+2, 2n+3 and 2n+4. Entries at or beyond twice the row length in macroblocks read unavailable.
- R7: One cycle after `row_start`, slots 7..9 are unavailable and slots 4, 5 and 6 hold line-store entries 0, 1 and 2.
- R8: `ready` is low for exactly three cycles after the edge that samples `mb_done`. The strobes may only be raised while `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Clears all slots and the line store |
| row_start | input | 1 | Clears left slots, loads above slots for macroblock 0 |
| mb_done | input | 1 | Current macroblock vectors are valid; starts the update |
| mb_idx | input | IDXW | Macroblock index within the row |
| mb_part | input | 2 | Partition type, encoded as in R2 |
| mb_intra | input | 1 | Current macroblock has no vectors |
| mb_mv_x | input | 4*MVW | Horizontal components, source k at bits [k*MVW +: MVW] |
| mb_mv_y | input | 4*MVW | Vertical components, same packing |
| rd_sel | input | 4 | Slot select code |
| rd_av | output | 1 | Selected slot is available |
| rd_x | output | MVW | Selected horizontal component |
| rd_y | output | MVW | Selected vertical component |
| ready | output | 1 | Idle and able to accept a strobe |

## Verification
On every cycle, the assertions check:
- the busy window length and that strobes arrive only while idle;
- that frame start clears every availability flag and row start clears the left flags;
- that step one moves the availability of the right column into the left slots;
- that the current slots do not change while idle.

The vector values themselves can only be shown by the bench's scenarios. These include partition duplication, values that pass through the line store into the next row, the fetch past the right picture edge, and the intra case.

// File: rtl/mv_nbr_pkg.sv
package mv_nbr_pkg;
    parameter int MVW   = 16;
    parameter int NSLOT = 10;

    typedef struct packed {
        logic                  av;
        logic signed [MVW-1:0] x;
        logic signed [MVW-1:0] y;
    } mv_t;

    typedef enum logic [1:0] {PART_16X16, PART_16X8, PART_8X16, PART_8X8} part_e;
    typedef enum logic [1:0] {ST_IDLE, ST_LEFT, ST_STORE, ST_FETCH} upd_e;

    localparam int S_X0 = 0;
    localparam int S_X1 = 1;
    localparam int S_X2 = 2;
    localparam int S_X3 = 3;
    localparam int S_U2 = 4;
    localparam int S_U3 = 5;
    localparam int S_UR = 6;
    localparam int S_LU = 7;
    localparam int S_LA = 8;
    localparam int S_LB = 9;
endpackage

// File: rtl/mv_nbr_expand.sv
module mv_nbr_expand
    import mv_nbr_pkg::*;
(
    input  logic [1:0]       part,
    input  logic             intra,
    input  logic [4*MVW-1:0] mv_x,
    input  logic [4*MVW-1:0] mv_y,
    output mv_t  [3:0]       blk
);
    for (genvar k = 0; k < 4; k++) begin : g_blk
        logic [1:0] src;
        always_comb begin
            case (part_e'(part))
                PART_16X16: src = 2'd0;
                PART_16X8:  src = 2'(k >> 1);
                PART_8X16:  src = 2'(k & 1);
                default:    src = 2'(k);
            endcase
            blk[k].av = !intra;
            blk[k].x  = intra ? '0 : mv_x[src*MVW +: MVW];
            blk[k].y  = intra ? '0 : mv_y[src*MVW +: MVW];
        end
    end
endmodule

// File: rtl/mv_nbr_line.sv
module mv_nbr_line
    import mv_nbr_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] wr_base,
    input  mv_t           wr_lo,
    input  mv_t           wr_hi,
    input  logic [AW-1:0] rd_base,
    output mv_t           rd0,
    output mv_t           rd1,
    output mv_t           rd2
);
    typedef struct packed {
        mv_t [ENTRIES-1:0] ent;
    } line_s;

    line_s line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (clr) begin
            line_d.ent = '0;
        end else if (we) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_base == AW'(i))          line_d.ent[i] = wr_lo;
                if (wr_base + AW'(1) == AW'(i)) line_d.ent[i] = wr_hi;
            end
        end
    end

    // entries at or past ENTRIES model the picture edge: unavailable
    always_comb begin
        rd0 = '0;
        rd1 = '0;
        rd2 = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rd_base == AW'(i))          rd0 = line_q.ent[i];
            if (rd_base + AW'(1) == AW'(i)) rd1 = line_q.ent[i];
            if (rd_base + AW'(2) == AW'(i)) rd2 = line_q.ent[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end
endmodule

// File: rtl/mv_nbr_buf.sv
module mv_nbr_buf
    import mv_nbr_pkg::*;
#(
    parameter int MB_PER_ROW = 8,
    localparam int IDXW = (MB_PER_ROW > 1) ? $clog2(MB_PER_ROW) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic                  row_start,
    input  logic                  mb_done,
    input  logic [IDXW-1:0]       mb_idx,
    input  logic [1:0]            mb_part,
    input  logic                  mb_intra,
    input  logic [4*MVW-1:0]      mb_mv_x,
    input  logic [4*MVW-1:0]      mb_mv_y,
    input  logic [3:0]            rd_sel,
    output logic                  rd_av,
    output logic signed [MVW-1:0] rd_x,
    output logic signed [MVW-1:0] rd_y,
    output logic                  ready
);
    localparam int WB = 2 * MB_PER_ROW;
    localparam int AW = $clog2(WB + 5);

    typedef struct packed {
        upd_e              st;
        logic [IDXW-1:0]   idx;
        mv_t [NSLOT-1:0]   slot;
    } state_s;

    state_s st_d, st_q;

    mv_t [3:0]     blk;
    mv_t           ln0, ln1, ln2;
    logic          line_clr, line_we;
    logic [AW-1:0] base_wr, base_rd;
    logic [1:0]    st_obs;
    logic [NSLOT-1:0] av_obs;

    mv_nbr_expand u_expand (
        .part  (mb_part),
        .intra (mb_intra),
        .mv_x  (mb_mv_x),
        .mv_y  (mb_mv_y),
        .blk   (blk)
    );

    assign base_wr  = AW'({st_q.idx, 1'b0});
    assign base_rd  = (st_q.st == ST_IDLE) ? '0 : base_wr + AW'(2);
    assign line_clr = (st_q.st == ST_IDLE) && frame_start;
    assign line_we  = (st_q.st == ST_STORE);

    mv_nbr_line #(.ENTRIES(WB), .AW(AW)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (line_clr),
        .we      (line_we),
        .wr_base (base_wr),
        .wr_lo   (st_q.slot[S_X2]),
        .wr_hi   (st_q.slot[S_X3]),
        .rd_base (base_rd),
        .rd0     (ln0),
        .rd1     (ln1),
        .rd2     (ln2)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.st)
            ST_IDLE: begin
                if (frame_start) begin
                    st_d.slot = '0;
                end else if (row_start) begin
                    st_d.slot[S_LU] = '0;
                    st_d.slot[S_LA] = '0;
                    st_d.slot[S_LB] = '0;
                    st_d.slot[S_U2] = ln0;
                    st_d.slot[S_U3] = ln1;
                    st_d.slot[S_UR] = ln2;
                end else if (mb_done) begin
                    for (int k = 0; k < 4; k++) st_d.slot[S_X0 + k] = blk[k];
                    st_d.idx = mb_idx;
                    st_d.st  = ST_LEFT;
                end
            end
            ST_LEFT: begin
                st_d.slot[S_LU] = st_q.slot[S_U3];
                st_d.slot[S_LA] = st_q.slot[S_X1];
                st_d.slot[S_LB] = st_q.slot[S_X3];
                st_d.st = ST_STORE;
            end
            ST_STORE: begin
                st_d.st = ST_FETCH;
            end
            default: begin
                st_d.slot[S_U2] = ln0;
                st_d.slot[S_U3] = ln1;
                st_d.slot[S_UR] = ln2;
                st_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: ST_IDLE, idx: '0, slot: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        rd_av = 1'b0;
        rd_x  = '0;
        rd_y  = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (rd_sel == 4'(s)) begin
                rd_av = st_q.slot[s].av;
                rd_x  = st_q.slot[s].x;
                rd_y  = st_q.slot[s].y;
            end
        end
    end

    assign ready  = (st_q.st == ST_IDLE);
    assign st_obs = st_q.st;
    for (genvar s = 0; s < NSLOT; s++) begin : g_obs
        assign av_obs[s] = st_q.slot[s].av;
    end
endmodule

// File: rtl/mv_nbr_chk.sv
module mv_nbr_chk
    import mv_nbr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             row_start,
    input logic             mb_done,
    input logic             ready,
    input logic [1:0]       state,
    input logic [NSLOT-1:0] slot_av
);
    logic [2:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (ready) busy_cnt <= '0;
        else            busy_cnt <= busy_cnt + 3'd1;
    end

    p_strobe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_done || row_start || frame_start) |-> ready);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mb_done |=> !ready);

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (busy_cnt < 3'd3));

    p_frame_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (slot_av == '0));

    p_row_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_start && !frame_start) |=> (slot_av[S_LB:S_LU] == '0));

    p_left_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'(ST_LEFT)) |=>
            (slot_av[S_LU] == $past(slot_av[S_U3])) &&
            (slot_av[S_LA] == $past(slot_av[S_X1])) &&
            (slot_av[S_LB] == $past(slot_av[S_X3])));

    p_cur_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !mb_done && !frame_start) |=> $stable(slot_av[S_X3:S_X0]));
endmodule

bind mv_nbr_buf mv_nbr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .row_start   (row_start),
    .mb_done     (mb_done),
    .ready       (ready),
    .state       (st_obs),
    .slot_av     (av_obs)
);

// File: tb/mv_nbr_buf_tb.sv
`timescale 1ns/1ps
module mv_nbr_buf_tb_top;
    localparam int MBR = 4;
    localparam int WB  = 2 * MBR;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        frame_start = 0, row_start = 0, mb_done = 0, mb_intra = 0;
    logic [1:0]  mb_idx = 0;
    logic [1:0]  mb_part = 0;
    logic [63:0] mb_mv_x = 0, mb_mv_y = 0;
    logic [3:0]  rd_sel = 0;
    logic        rd_av, ready;
    logic signed [15:0] rd_x, rd_y;

    always #4 clk = ~clk;

    mv_nbr_buf #(.MB_PER_ROW(MBR)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_start(row_start),
        .mb_done(mb_done), .mb_idx(mb_idx), .mb_part(mb_part), .mb_intra(mb_intra),
        .mb_mv_x(mb_mv_x), .mb_mv_y(mb_mv_y), .rd_sel(rd_sel),
        .rd_av(rd_av), .rd_x(rd_x), .rd_y(rd_y), .ready(ready)
    );

    typedef struct {
        int    sel;
        bit    av;
        int    x;
        int    y;
        string req;
    } item_t;

    item_t sb_q[$];
    int    total = 0, bad = 0;
    bit    mon_busy = 0, finished = 0;

    // model of slots and line store, built from the requirements
    bit m_av[10]; int m_x[10]; int m_y[10];
    bit l_av[WB]; int l_x[WB]; int l_y[WB];

    task automatic push_all(string req);
        for (int s = 0; s < 10; s++) begin
            item_t it;
            it.sel = s; it.av = m_av[s]; it.x = m_x[s]; it.y = m_y[s]; it.req = req;
            sb_q.push_back(it);
        end
        while (sb_q.size() != 0 || mon_busy) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares them against the read port
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                mon_busy = 1;
                it = sb_q.pop_front();
                rd_sel = 4'(it.sel);
                #1;
                total++;
                if (rd_av !== it.av || (it.av && (int'(rd_x) != it.x || int'(rd_y) != it.y))) begin
                    bad++;
                    $display("FAIL %s slot %0d: got av=%0d (%0d,%0d) exp av=%0d (%0d,%0d)",
                             it.req, it.sel, rd_av, rd_x, rd_y, it.av, it.x, it.y);
                end
                mon_busy = 0;
            end
        end
    end

    task automatic check_val(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic do_frame();
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
        for (int s = 0; s < 10; s++) m_av[s] = 0;
        for (int i = 0; i < WB; i++) l_av[i] = 0;
    endtask

    task automatic do_row();
        @(negedge clk); row_start = 1;
        @(negedge clk); row_start = 0;
        m_av[7] = 0; m_av[8] = 0; m_av[9] = 0;
        for (int k = 0; k < 3; k++) begin
            m_av[4+k] = l_av[k]; m_x[4+k] = l_x[k]; m_y[4+k] = l_y[k];
        end
    endtask

    task automatic do_mb(int n, int part, bit intra, int vx[4], int vy[4], string req);
        int src; int busy;
        @(negedge clk);
        mb_idx = 2'(n); mb_part = 2'(part); mb_intra = intra;
        for (int k = 0; k < 4; k++) begin
            mb_mv_x[k*16 +: 16] = 16'(vx[k]);
            mb_mv_y[k*16 +: 16] = 16'(vy[k]);
        end
        mb_done = 1;
        @(negedge clk); mb_done = 0;
        busy = 0;
        while (!ready && busy < 10) begin busy++; @(negedge clk); end
        check_val("R8 busy cycles", busy, 3);
        for (int k = 0; k < 4; k++) begin
            case (part)
                0: src = 0;
                1: src = k / 2;
                2: src = k % 2;
                default: src = k;
            endcase
            m_av[k] = !intra; m_x[k] = vx[src]; m_y[k] = vy[src];
        end
        m_av[7] = m_av[5]; m_x[7] = m_x[5]; m_y[7] = m_y[5];
        m_av[8] = m_av[1]; m_x[8] = m_x[1]; m_y[8] = m_y[1];
        m_av[9] = m_av[3]; m_x[9] = m_x[3]; m_y[9] = m_y[3];
        l_av[2*n] = m_av[2]; l_x[2*n] = m_x[2]; l_y[2*n] = m_y[2];
        l_av[2*n+1] = m_av[3]; l_x[2*n+1] = m_x[3]; l_y[2*n+1] = m_y[3];
        for (int k = 0; k < 3; k++) begin
            int e = 2*n + 2 + k;
            if (e < WB) begin m_av[4+k] = l_av[e]; m_x[4+k] = l_x[e]; m_y[4+k] = l_y[e]; end
            else m_av[4+k] = 0;
        end
        push_all(req);
    endtask

    initial begin
        for (int s = 0; s < 10; s++) begin m_av[s] = 0; m_x[s] = 0; m_y[s] = 0; end
        for (int i = 0; i < WB; i++) begin l_av[i] = 0; l_x[i] = 0; l_y[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_val("R1 ready after reset", int'(ready), 1);
        push_all("R1 reset state");

        do_frame();
        push_all("R1 frame start");
        do_row();
        push_all("R7 first row start");

        do_mb(0, 0, 0, '{10, 0, 0, 0}, '{-3, 0, 0, 0}, "R2 16x16 R4 left copy");
        do_mb(1, 1, 0, '{1, 3, 0, 0}, '{2, 4, 0, 0}, "R2 16x8");
        do_mb(2, 2, 0, '{5, -7, 0, 0}, '{6, 8, 0, 0}, "R2 8x16");
        do_mb(3, 3, 0, '{11, 12, 13, 14}, '{-21, -22, -23, -24}, "R2 8x8 R6 edge");

        do_row();
        push_all("R7 R5 second row start");
        do_mb(0, 3, 1, '{99, 98, 97, 96}, '{1, 1, 1, 1}, "R3 intra R6 fetch");
        do_mb(1, 3, 0, '{-100, 200, -300, 400}, '{7, 8, 9, 10}, "R5 R6 8x8 second row");
        do_mb(2, 0, 0, '{32767, 0, 0, 0}, '{-32768, 0, 0, 0}, "R2 extreme values");

        do_frame();
        push_all("R1 second frame");
        do_row();
        push_all("R1 R7 line cleared");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule